// File: doc/BRIEF.md
# Periodic Down-Counting Slice Timer

This block is a small timer peripheral. It sits on a simple register bus and runs from the bus clock. Software programs a reload value and sets the control bits. The counter then steps down by one on every clock until it reaches zero. On the following clock it reloads the programmed value. A programmed value of N therefore gives a period of N + 1 clocks, so software writes n − 1 to get a period of n clocks.

Every pass through zero sets a sticky timeout flag. When interrupts are enabled, this flag drives the interrupt line. Software can read the live counter at any time and combine it with its own tick count to build a fine-grained timestamp. An access to an address outside the register map sets a second sticky flag that records a bus error. Both flags sit in one status word, and software clears either one by writing a one to its bit position.

Top module: `periodic_slice_timer`

## Requirements
- R1: While the run bit and the timer-enable bit are both set and the count is not zero, the count drops by exactly one on each clock.
- R2: While counting, a count of zero is replaced on the next clock by the reload value, so a reload value of N gives a period of N + 1 clocks. A reload value of 0 makes the counter wrap on every clock.
- R3: While either the run bit or the timer-enable bit is clear, the count holds its value.
- R4: A bus write to offset 0x0 stores the reload value. If the timer is not counting, the same write also loads the count on that clock. If the timer is counting, the count is left alone and the new value takes effect at the next reload.
- R5: The control word at offset 0x4 reads back as written. Bit 0 is run, bit 1 is interrupt enable and bit 2 is timer enable. A write to the control word takes effect on the clock after the write.
- R6: Bit 0 of the status word at offset 0xC is the timeout flag. It is set on the clock where the count reloads from zero. It then stays set until software clears it, and nothing else sets it.
- R7: Writing a 1 to bit 0 of the status word clears the timeout flag. If a wrap happens on the same clock as that write, the flag stays set.
- R8: Bit 1 of the status word is the bus-error flag. Any access, read or write, to an offset that is not word aligned or that lies above 0xC sets this flag. Writing a 1 to bit 1 of the status word clears it.
- R9: The interrupt output is high exactly while the timeout flag is set and the interrupt-enable bit is set.
- R10: A read at offset 0x0 returns the reload value. A read at 0x8 returns the live count. A read at an undefined offset returns zero. A write to 0x8 has no effect on the count.
- R11: After reset, the reload value, the count, the control word and both flags are zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the counter steps on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one clock per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Read data, valid in the cycle of a read strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker checks the counting rules on every clock: decrement, reload from zero, hold while stopped, and an immediate load only while stopped. It also checks that the timeout flag is set on a wrap, stays set, and clears on a one-write except when a wrap happens on the same clock. It further checks that bad addresses raise the bus-error flag and read as zero. The bench scenarios are what show the behaviour seen by software. These are the exact N + 1 period seen through live-count reads, and a new reload value landing only at the next wrap. They also cover the read-back of the control and status words, the masking of the interrupt by its enable, a write to the count being ignored, and the state after a reset applied mid-run.

// File: rtl/pst_pkg.sv
package pst_pkg;

    // register word index = byte offset >> 2
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // control word: bit2 timer enable, bit1 irq enable, bit0 run
    typedef struct packed {
        logic ten;
        logic ien;
        logic run;
    } ctrl_t;

    // status word: bit1 bus error, bit0 timeout
    typedef struct packed {
        logic bus_err;
        logic timeout;
    } status_t;

    typedef struct packed {
        logic     reload_wr;
        logic     ctrl_wr;
        logic     status_wr;
        logic     rd_en;
        logic     bad;
        reg_sel_e sel;
    } access_t;

endpackage

// File: rtl/pst_decode.sv
module pst_decode
    import pst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc
);

    logic upper_zero;
    logic in_map;

    generate
        if (ADDR_W > 4) begin : g_wide
            assign upper_zero = (addr[ADDR_W-1:4] == '0);
        end else begin : g_narrow
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        in_map        = upper_zero && (addr[1:0] == 2'b00);
        acc           = '0;
        acc.sel       = reg_sel_e'(addr[3:2]);
        acc.bad       = sel && !in_map;
        acc.rd_en     = sel && !wr && in_map;
        acc.reload_wr = sel && wr && in_map && (acc.sel == SEL_RELOAD);
        acc.ctrl_wr   = sel && wr && in_map && (acc.sel == SEL_CTRL);
        acc.status_wr = sel && wr && in_map && (acc.sel == SEL_STATUS);
    end

endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             wrap
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = en && (st_q.count == '0);
        if (load) begin
            st_d.reload = load_val;
        end
        if (en) begin
            if (wrap) begin
                st_d.count = st_q.reload;
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end else if (load) begin
            st_d.count = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count  = st_q.count;
    assign reload = st_q.reload;

endmodule

// File: rtl/pst_flags.sv
module pst_flags
    import pst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wrap,
    input  logic    bad,
    input  logic    clr_wr,
    input  status_t clr_mask,
    output status_t flags
);

    status_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_wr) begin
            if (clr_mask.timeout) fl_d.timeout = 1'b0;
            if (clr_mask.bus_err) fl_d.bus_err = 1'b0;
        end
        // new events win over a clear in the same cycle
        if (wrap) fl_d.timeout = 1'b1;
        if (bad)  fl_d.bus_err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/periodic_slice_timer.sv
module periodic_slice_timer
    import pst_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(status_t);

    access_t          acc;
    ctrl_t            ctrl_d, ctrl_q;
    status_t          flags;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             wrap;
    logic             cnt_en;

    pst_decode #(.ADDR_W(ADDR_W)) u_decode (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .acc  (acc)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (acc.ctrl_wr) begin
            ctrl_d = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cnt_en = ctrl_q.run && ctrl_q.ten;

    pst_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cnt_en),
        .load     (acc.reload_wr),
        .load_val (bus_wdata),
        .count    (cnt_q),
        .reload   (reload_q),
        .wrap     (wrap)
    );

    pst_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .bad      (acc.bad),
        .clr_wr   (acc.status_wr),
        .clr_mask (status_t'(bus_wdata[STAT_W-1:0])),
        .flags    (flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc.rd_en) begin
            unique case (acc.sel)
                SEL_RELOAD: bus_rdata = reload_q;
                SEL_CTRL:   bus_rdata = CNT_W'(ctrl_q);
                SEL_COUNT:  bus_rdata = cnt_q;
                SEL_STATUS: bus_rdata = CNT_W'(flags);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = flags.timeout && ctrl_q.ien;

endmodule

// File: rtl/pst_checker.sv
module pst_checker #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  rdata,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input logic              run,
    input logic              ien,
    input logic              ten,
    input logic              timeout,
    input logic              bus_err
);

    logic counting, at_zero, reload_write, to_clear, bad_addr;

    always_comb begin
        counting     = run && ten;
        at_zero      = (count == '0);
        bad_addr     = (addr[1:0] != 2'b00) || (addr > ADDR_W'(12));
        reload_write = sel && wr && (addr == '0);
        to_clear     = sel && wr && (addr == ADDR_W'(12)) && wdata[0];
    end

    p_decrement_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !at_zero) |=> (count == $past(count) - 1'b1));

    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && at_zero) |=> (count == $past(reload)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && !reload_write) |=> $stable(count));

    p_load_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!counting && reload_write) |=> (count == $past(wdata)));

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && at_zero) |=> timeout);

    p_rise_only_on_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(counting && at_zero));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !to_clear) |=> timeout);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clear && !(counting && at_zero)) |=> !timeout);

    p_bus_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && bad_addr) |=> bus_err);

    p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && at_zero && ien && !(sel && wr && addr == ADDR_W'(4))) |=> irq);

    p_undef_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && bad_addr) |-> (rdata == '0));

endmodule

bind periodic_slice_timer pst_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pst_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .irq     (irq),
    .count   (cnt_q),
    .reload  (reload_q),
    .run     (ctrl_q.run),
    .ien     (ctrl_q.ien),
    .ten     (ctrl_q.ten),
    .timeout (flags.timeout),
    .bus_err (flags.bus_err)
);

// File: tb/tb_periodic_slice_timer.sv
`timescale 1ns/1ps
module tb_periodic_slice_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    periodic_slice_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct packed {
        logic        s;
        logic        w;
        logic [7:0]  a;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic        eirq;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    // one bus cycle per entry; expectations reflect state before that cycle's edge
    localparam vec_t TBL [NV] = '{
        '{1'b1, 1'b0, 8'h00, 32'd0, 1'b1, 32'd0, 1'b0, 8'd10}, // R10 reload reads 0
        '{1'b1, 1'b1, 8'h00, 32'd3, 1'b0, 32'd0, 1'b0, 8'd4},  // R4 load while stopped
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd3, 1'b0, 8'd4},  // R4 count loaded
        '{1'b1, 1'b1, 8'h04, 32'd7, 1'b0, 32'd0, 1'b0, 8'd5},  // R5 run|ien|ten
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd3, 1'b0, 8'd3},  // R3 held during ctrl write
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd2, 1'b0, 8'd1},  // R1
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd1, 1'b0, 8'd1},  // R1
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd0, 1'b0, 8'd1},  // R1 zero reached
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd1, 1'b1, 8'd6},  // R6 flag set, irq
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd2, 1'b1, 8'd2},  // R2 reloaded 3 then 2
        '{1'b1, 1'b1, 8'h0C, 32'd1, 1'b0, 32'd0, 1'b1, 8'd7},  // R7 clear
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd0, 1'b0, 8'd7},  // R7 cleared
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd3, 1'b1, 8'd2},  // R2 period of 4
        '{1'b1, 1'b1, 8'h04, 32'd5, 1'b0, 32'd0, 1'b1, 8'd5},  // R5 drop ien
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd1, 1'b0, 8'd9},  // R9 masked
        '{1'b1, 1'b1, 8'h0C, 32'd1, 1'b0, 32'd0, 1'b0, 8'd7},  // R7 clear at wrap
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd1, 1'b0, 8'd7},  // R7 wrap wins
        '{1'b1, 1'b1, 8'h04, 32'd0, 1'b0, 32'd0, 1'b0, 8'd5},  // R5 stop
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd1, 1'b0, 8'd3},  // R3
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd1, 1'b0, 8'd3},  // R3 held
        '{1'b1, 1'b1, 8'h0C, 32'd1, 1'b0, 32'd0, 1'b0, 8'd7},  // R7
        '{1'b1, 1'b0, 8'h10, 32'd0, 1'b1, 32'd0, 1'b0, 8'd10}, // R10 undefined read
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd2, 1'b0, 8'd8},  // R8 bus error set
        '{1'b1, 1'b1, 8'h0C, 32'd2, 1'b0, 32'd0, 1'b0, 8'd8},  // R8 clear
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd0, 1'b0, 8'd8},  // R8 cleared
        '{1'b1, 1'b0, 8'h04, 32'd0, 1'b1, 32'd0, 1'b0, 8'd5},  // R5 reads 0
        '{1'b1, 1'b1, 8'h04, 32'd6, 1'b0, 32'd0, 1'b0, 8'd5},  // R5 ien|ten, no run
        '{1'b1, 1'b0, 8'h08, 32'd0, 1'b1, 32'd1, 1'b0, 8'd3},  // R3 run clear holds
        '{1'b1, 1'b0, 8'h04, 32'd0, 1'b1, 32'd6, 1'b0, 8'd5},  // R5 readback
        '{1'b1, 1'b0, 8'h02, 32'd0, 1'b1, 32'd0, 1'b0, 8'd10}, // R10 misaligned
        '{1'b1, 1'b0, 8'h0C, 32'd0, 1'b1, 32'd2, 1'b0, 8'd8}   // R8 misaligned flagged
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_step(input logic s, input logic w, input logic [7:0] a,
                           input logic [31:0] wd, input logic chk,
                           input logic [31:0] exp_rd, input logic exp_irq, input int req);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        #1;
        if (chk) check(bus_rdata, exp_rd, req, "rdata");
        check({31'b0, irq}, {31'b0, exp_irq}, req, "irq");
        @(posedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            do_step(TBL[i].s, TBL[i].w, TBL[i].a, TBL[i].wd, TBL[i].chk,
                    TBL[i].exp, TBL[i].eirq, int'(TBL[i].req));
        end

        // R11: reset in the middle of activity clears everything
        do_reset();
        do_step(1, 0, 8'h00, 0, 1, 32'd0, 0, 11);
        do_step(1, 0, 8'h04, 0, 1, 32'd0, 0, 11);
        do_step(1, 0, 8'h08, 0, 1, 32'd0, 0, 11);
        do_step(1, 0, 8'h0C, 0, 1, 32'd0, 0, 11);

        // R10: count register ignores writes
        do_step(1, 1, 8'h00, 32'd9, 0, 0, 0, 10);
        do_step(1, 1, 8'h08, 32'd4, 0, 0, 0, 10);
        do_step(1, 0, 8'h08, 0, 1, 32'd9, 0, 10);

        // R4: reload written while counting takes effect at the next wrap
        do_reset();
        do_step(1, 1, 8'h00, 32'd2, 0, 0, 0, 4);
        do_step(1, 1, 8'h04, 32'd7, 0, 0, 0, 4);
        do_step(1, 1, 8'h00, 32'd5, 0, 0, 0, 4);
        do_step(1, 0, 8'h08, 0, 1, 32'd1, 0, 4);
        do_step(1, 0, 8'h08, 0, 1, 32'd0, 0, 4);
        do_step(1, 0, 8'h08, 0, 1, 32'd5, 1, 4);
        do_step(1, 0, 8'h00, 0, 1, 32'd5, 1, 4);

        // R2: reload of 0 wraps on every clock; R7 clear loses to that wrap
        do_reset();
        do_step(1, 1, 8'h00, 32'd0, 0, 0, 0, 2);
        do_step(1, 1, 8'h04, 32'd5, 0, 0, 0, 2);
        do_step(1, 0, 8'h0C, 0, 1, 32'd0, 0, 2);
        do_step(1, 0, 8'h0C, 0, 1, 32'd1, 0, 2);
        do_step(1, 0, 8'h08, 0, 1, 32'd0, 0, 2);
        do_step(1, 1, 8'h0C, 32'd1, 0, 0, 0, 7);
        do_step(1, 0, 8'h0C, 0, 1, 32'd1, 0, 7);

        @(negedge clk);
        bus_sel = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule